// File: doc/BRIEF.md
# Compact Sharer-Tracking Directory Entry

This block holds the update and decode logic for one compact directory entry in a 64-processor shared-memory system. It records which nodes other than the block's home currently hold a copy of the memory block. While only one remote node holds the block, the entry stores that node's exact number. When a second, different node joins, the same field becomes a coarse vector with one bit per group of eight processors. From that point, invalidations are sent to every processor in a marked group, so some of them are extra.

A protocol controller drives the command port. It adds sharers, wipes the entry, or asks for an invalidation sweep. During a sweep the block produces the target node numbers one at a time on a valid/ready output, in ascending order, and never targets the home node. It then pulses a done strobe and leaves the entry empty.

The controller sits in one of three named states. In `IDLE` it takes commands. In `WALK` it hands out invalidation targets. `FINISH` lasts one cycle and raises the done pulse. The transitions are IDLE→WALK (invalidate command accepted), WALK→WALK (targets still pending), WALK→FINISH (no target left once the current handshake is counted) and FINISH→IDLE (always).

Top module: `sharer_dir_entry`

## Requirements
- R1: After reset `entry_valid`, `entry_coarse`, `entry_field`, `inv_valid` and `inv_done` are 0, and `cmd_ready` is 1.
- R2: Command codes on `cmd_op` are 0 = no-op, 1 = add sharer, 2 = clear, 3 = invalidate. An add of a non-home node to an empty entry gives `entry_valid`=1, `entry_coarse`=0 and `entry_field` equal to the node number, zero-extended, after the accepting edge.
- R3: In pointer mode, an add of the node that is already stored leaves all three entry outputs unchanged.
- R4: In pointer mode, an add of a different node sets `entry_coarse`=1. `entry_field` then holds exactly the group bits of the old node and the new node, where the bit index is node number divided by 8.
- R5: In coarse mode, an add sets bit (node/8) of `entry_field` and leaves the other bits unchanged.
- R6: An add whose node equals `home_id` does not change the entry in any mode.
- R7: A clear command zeroes `entry_valid`, `entry_coarse` and `entry_field` at the next edge and produces no invalidation.
- R8: An invalidate in pointer mode emits exactly the stored node, once.
- R9: An invalidate in coarse mode emits every node of each marked group except `home_id`, each exactly once and in strictly ascending order. `inv_node` holds steady while `inv_valid` is high and `inv_ready` is low.
- R10: `inv_done` is high for exactly one cycle. That cycle directly follows the last accepted target. During it, the entry outputs are already zero, and `cmd_ready` returns to 1 in the next cycle.
- R11: An invalidate of an empty entry emits nothing, and `inv_done` rises one cycle after the walk begins.
- R12: `cmd_ready` is 0 throughout a sweep and during the done cycle, and a command presented then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| home_id | input | 6 | Node number of the block's home, held static |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_node | input | 6 | Node number for an add command |
| cmd_ready | output | 1 | Command accepted this cycle when high together with cmd_valid |
| entry_valid | output | 1 | Entry records at least one remote sharer |
| entry_coarse | output | 1 | Entry is in group-vector mode |
| entry_field | output | 8 | Pointer or group vector |
| inv_valid | output | 1 | Invalidation target available |
| inv_node | output | 6 | Invalidation target node number |
| inv_ready | input | 1 | Consumer takes the current target |
| inv_done | output | 1 | One-cycle pulse ending a sweep |

## Verification
The entry outputs are registered and the add, clear and invalidate commands read them directly, so a wrong mode bit or field bit shows at the ports on the edge after the command. Two failures would be caught later, only by the following sweep: a bad pending set in the walker, and a wrong group expansion. They appear there as a missing, repeated, out-of-order or home-node target. They can also appear as a done pulse that comes early or late compared with the last handshake. The sweep tests therefore compare the whole set of emitted targets, and the cycle in which done rises, against values the bench works out for itself.

// File: rtl/dir_entry_pkg.sv
package dir_entry_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_ADD   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_INVAL = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } walk_state_e;

endpackage

// File: rtl/dir_field_update.sv
// Next-value logic for an add-sharer command.
module dir_field_update #(
    parameter int NODES    = 64,
    parameter int GROUP_SZ = 8,
    parameter int NODE_W   = $clog2(NODES),
    parameter int FIELD_W  = 8
) (
    input  logic               add_en,
    input  logic [NODE_W-1:0]  node,
    input  logic [NODE_W-1:0]  home,
    input  logic               cur_valid,
    input  logic               cur_coarse,
    input  logic [FIELD_W-1:0] cur_field,
    output logic               nxt_valid,
    output logic               nxt_coarse,
    output logic [FIELD_W-1:0] nxt_field
);
    localparam int SHIFT = $clog2(GROUP_SZ);

    logic [NODE_W-1:0] old_ptr;
    logic [NODE_W-1:0] new_grp;
    logic [NODE_W-1:0] old_grp;

    always_comb begin
        old_ptr = cur_field[NODE_W-1:0];
        new_grp = node >> SHIFT;
        old_grp = old_ptr >> SHIFT;

        nxt_valid  = cur_valid;
        nxt_coarse = cur_coarse;
        nxt_field  = cur_field;

        if (add_en && (node != home)) begin
            if (!cur_valid) begin
                nxt_valid  = 1'b1;
                nxt_coarse = 1'b0;
                nxt_field  = FIELD_W'(node);
            end else if (!cur_coarse) begin
                if (cur_field != FIELD_W'(node)) begin
                    nxt_coarse         = 1'b1;
                    nxt_field          = '0;
                    nxt_field[old_grp] = 1'b1;
                    nxt_field[new_grp] = 1'b1;
                end
            end else begin
                nxt_field[new_grp] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_target_expand.sv
// Turns the entry into a per-node target mask, home node removed.
module dir_target_expand #(
    parameter int NODES    = 64,
    parameter int GROUP_SZ = 8,
    parameter int NODE_W   = $clog2(NODES),
    parameter int FIELD_W  = 8
) (
    input  logic               ent_valid,
    input  logic               ent_coarse,
    input  logic [FIELD_W-1:0] ent_field,
    input  logic [NODE_W-1:0]  home,
    output logic [NODES-1:0]   targets
);
    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int GRP = n / GROUP_SZ;
        logic hit;
        always_comb begin
            if (ent_coarse)
                hit = ent_field[GRP];
            else
                hit = (ent_field == FIELD_W'(n));
            targets[n] = ent_valid && hit && (home != NODE_W'(n));
        end
    end
endmodule

// File: rtl/dir_lowest_pick.sv
// Lowest-index set bit of the pending mask.
module dir_lowest_pick #(
    parameter int NODES  = 64,
    parameter int NODE_W = $clog2(NODES)
) (
    input  logic [NODES-1:0]  pending,
    output logic              any,
    output logic [NODE_W-1:0] index,
    output logic [NODES-1:0]  onehot
);
    always_comb begin
        index = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pending[i]) index = NODE_W'(i);
        end
        any    = |pending;
        onehot = any ? (NODES'(1) << index) : '0;
    end
endmodule

// File: rtl/sharer_dir_entry.sv
module sharer_dir_entry
    import dir_entry_pkg::*;
#(
    parameter int NODES    = 64,
    parameter int GROUP_SZ = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NODES)-1:0]    home_id,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [$clog2(NODES)-1:0]    cmd_node,
    output logic                        cmd_ready,
    output logic                        entry_valid,
    output logic                        entry_coarse,
    output logic [((NODES/GROUP_SZ) > $clog2(NODES) ? (NODES/GROUP_SZ) : $clog2(NODES))-1:0] entry_field,
    output logic                        inv_valid,
    output logic [$clog2(NODES)-1:0]    inv_node,
    input  logic                        inv_ready,
    output logic                        inv_done
);
    localparam int NODE_W  = $clog2(NODES);
    localparam int GROUPS  = NODES / GROUP_SZ;
    localparam int FIELD_W = (GROUPS > NODE_W) ? GROUPS : NODE_W;

    walk_state_e state_q, state_d;

    logic               valid_q, coarse_q;
    logic [FIELD_W-1:0] field_q;
    logic [NODES-1:0]   pend_q, pend_d;

    logic               add_valid, add_coarse;
    logic [FIELD_W-1:0] add_field;
    logic [NODES-1:0]   targets;
    logic               pick_any;
    logic [NODE_W-1:0]  pick_idx;
    logic [NODES-1:0]   pick_oh;

    logic    accept, handshake;
    dir_op_e op;

    assign op        = dir_op_e'(cmd_op);
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign handshake = (state_q == ST_WALK) && pick_any && inv_ready;

    dir_field_update #(
        .NODES(NODES), .GROUP_SZ(GROUP_SZ), .NODE_W(NODE_W), .FIELD_W(FIELD_W)
    ) u_update (
        .add_en    (accept && (op == OP_ADD)),
        .node      (cmd_node),
        .home      (home_id),
        .cur_valid (valid_q),
        .cur_coarse(coarse_q),
        .cur_field (field_q),
        .nxt_valid (add_valid),
        .nxt_coarse(add_coarse),
        .nxt_field (add_field)
    );

    dir_target_expand #(
        .NODES(NODES), .GROUP_SZ(GROUP_SZ), .NODE_W(NODE_W), .FIELD_W(FIELD_W)
    ) u_expand (
        .ent_valid (valid_q),
        .ent_coarse(coarse_q),
        .ent_field (field_q),
        .home      (home_id),
        .targets   (targets)
    );

    dir_lowest_pick #(
        .NODES(NODES), .NODE_W(NODE_W)
    ) u_pick (
        .pending(pend_q),
        .any    (pick_any),
        .index  (pick_idx),
        .onehot (pick_oh)
    );

    // Pending target set for the current sweep
    always_comb begin
        pend_d = pend_q;
        if (accept && (op == OP_INVAL))
            pend_d = targets;
        else if (handshake)
            pend_d = pend_q & ~pick_oh;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && (op == OP_INVAL)) state_d = ST_WALK;
            ST_WALK:   if (pend_d == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Entry and pending registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            coarse_q <= 1'b0;
            field_q  <= '0;
            pend_q   <= '0;
        end else begin
            pend_q <= pend_d;
            if (state_q == ST_WALK && state_d == ST_FINISH) begin
                valid_q  <= 1'b0;
                coarse_q <= 1'b0;
                field_q  <= '0;
            end else if (accept && op == OP_CLEAR) begin
                valid_q  <= 1'b0;
                coarse_q <= 1'b0;
                field_q  <= '0;
            end else begin
                valid_q  <= add_valid;
                coarse_q <= add_coarse;
                field_q  <= add_field;
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_ready    = (state_q == ST_IDLE);
        inv_valid    = (state_q == ST_WALK) && pick_any;
        inv_node     = pick_idx;
        inv_done     = (state_q == ST_FINISH);
        entry_valid  = valid_q;
        entry_coarse = coarse_q;
        entry_field  = field_q;
    end
endmodule

// File: rtl/dir_entry_chk.sv
module dir_entry_chk #(
    parameter int NODE_W  = 6,
    parameter int FIELD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NODE_W-1:0]  home_id,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic               cmd_ready,
    input logic               entry_valid,
    input logic               entry_coarse,
    input logic [FIELD_W-1:0] entry_field,
    input logic               inv_valid,
    input logic [NODE_W-1:0]  inv_node,
    input logic               inv_ready,
    input logic               inv_done
);
    // R4
    coarse_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_coarse |-> entry_valid);

    // R6
    ptr_not_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && !entry_coarse) |-> (entry_field != FIELD_W'(home_id)));

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> (!entry_valid && entry_field == '0));

    // R9
    target_not_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != home_id));

    // R9
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node)));

    // R10
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> (!entry_valid && !entry_coarse && entry_field == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> (!inv_done && cmd_ready));

    // R12
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && (inv_valid || inv_done)));
endmodule

bind sharer_dir_entry dir_entry_chk #(
    .NODE_W(NODE_W), .FIELD_W(FIELD_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .home_id(home_id),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .entry_valid(entry_valid), .entry_coarse(entry_coarse), .entry_field(entry_field),
    .inv_valid(inv_valid), .inv_node(inv_node), .inv_ready(inv_ready), .inv_done(inv_done)
);

// File: tb/sharer_dir_entry_test.sv
`timescale 1ns/1ps
module sharer_dir_entry_test;
    localparam logic [5:0] HOME = 6'd10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] home_id = HOME;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [5:0] cmd_node = 6'd0;
    logic       cmd_ready;
    logic       entry_valid, entry_coarse;
    logic [7:0] entry_field;
    logic       inv_valid;
    logic [5:0] inv_node;
    logic       inv_ready = 1'b0;
    logic       inv_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sharer_dir_entry uut (
        .clk(clk), .rst_n(rst_n), .home_id(home_id),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node), .cmd_ready(cmd_ready),
        .entry_valid(entry_valid), .entry_coarse(entry_coarse), .entry_field(entry_field),
        .inv_valid(inv_valid), .inv_node(inv_node), .inv_ready(inv_ready), .inv_done(inv_done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] ent();
        return {entry_valid, entry_coarse, entry_field};
    endfunction

    task automatic issue(input logic [1:0] op, input logic [5:0] node);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_node = node;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic expect_entry(input bit v, input bit c, input logic [7:0] f, input string req);
        logic [9:0] exp;
        exp = {v, c, f};
        check(ent() == exp, req, 64'(ent()), 64'(exp));
    endtask

    // Runs a sweep; the sweep must have been started by the caller's issue of code 3.
    task automatic run_sweep(input logic [63:0] exp_mask, input bit stall, input string req);
        logic [63:0] got = '0;
        int  last = -1;
        bit  order_ok = 1'b1, hold_ok = 1'b1, busy_ok = 1'b1, timing_ok = 1'b0;
        bit  prev_stall = 1'b0, prev_acc = 1'b0, saw_done = 1'b0;
        logic [5:0] prev_node = '0;
        logic [9:0] at_done = '1;
        // hold an add of node 40 during the whole sweep (R12)
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_node = 6'd40;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (inv_done) begin
                saw_done  = 1'b1;
                timing_ok = (exp_mask == '0) ? (k == 1) : prev_acc;
                at_done   = ent();
                if (cmd_ready) busy_ok = 1'b0;
                break;
            end
            if (cmd_ready) busy_ok = 1'b0;
            prev_acc = 1'b0;
            if (inv_valid) begin
                if (prev_stall && inv_node != prev_node) hold_ok = 1'b0;
                inv_ready = stall ? (k % 3 != 2) : 1'b1;
                if (inv_ready) begin
                    if (int'(inv_node) <= last) order_ok = 1'b0;
                    got[inv_node] = 1'b1;
                    last = int'(inv_node);
                    prev_acc = 1'b1;
                end
                prev_stall = !inv_ready;
                prev_node  = inv_node;
            end else begin
                inv_ready  = 1'b0;
                prev_stall = 1'b0;
            end
        end
        cmd_valid = 1'b0; cmd_op = 2'd0; inv_ready = 1'b0;
        check(saw_done, {req, " R10 done seen"}, 64'(saw_done), 64'd1);
        check(got == exp_mask, {req, " target set"}, got, exp_mask);
        check(order_ok, {req, " R9 ascending"}, 64'(order_ok), 64'd1);
        check(hold_ok, {req, " R9 stall hold"}, 64'(hold_ok), 64'd1);
        check(timing_ok, {req, " R10 done timing"}, 64'(timing_ok), 64'd1);
        check(at_done == 10'd0, {req, " R10 empty at done"}, 64'(at_done), 64'd0);
        check(busy_ok, {req, " R12 not ready while busy"}, 64'(busy_ok), 64'd1);
        @(posedge clk); #1;
        check(cmd_ready == 1'b1, {req, " R10 ready after done"}, 64'(cmd_ready), 64'd1);
        check(entry_valid == 1'b0, {req, " R12 held add not taken"}, 64'(entry_valid), 64'd0);
    endtask

    task automatic t_reset();
        expect_entry(1'b0, 1'b0, 8'h00, "R1 entry");
        check({cmd_ready, inv_valid, inv_done} == 3'b100, "R1 handshake",
              64'({cmd_ready, inv_valid, inv_done}), 64'b100);
    endtask

    task automatic t_pointer();
        issue(2'd1, 6'd5);
        expect_entry(1'b1, 1'b0, 8'd5, "R2 first add");
        issue(2'd1, 6'd5);
        expect_entry(1'b1, 1'b0, 8'd5, "R3 same node");
        issue(2'd1, HOME);
        expect_entry(1'b1, 1'b0, 8'd5, "R6 home in pointer mode");
        issue(2'd3, 6'd0);
        run_sweep(64'd1 << 5, 1'b0, "R8 pointer sweep");
    endtask

    task automatic t_coarse();
        logic [63:0] m;
        issue(2'd1, HOME);
        expect_entry(1'b0, 1'b0, 8'h00, "R6 home on empty");
        issue(2'd1, 6'd20);
        issue(2'd1, 6'd3);
        expect_entry(1'b1, 1'b1, 8'h05, "R4 convert");
        issue(2'd1, 6'd63);
        expect_entry(1'b1, 1'b1, 8'h85, "R5 new group");
        issue(2'd1, 6'd21);
        expect_entry(1'b1, 1'b1, 8'h85, "R5 existing group");
        issue(2'd1, HOME);
        expect_entry(1'b1, 1'b1, 8'h85, "R6 home in coarse mode");
        m = '0;
        for (int n = 0; n < 64; n++) if ((n / 8) inside {0, 2, 7}) m[n] = 1'b1;
        issue(2'd3, 6'd0);
        run_sweep(m, 1'b1, "R9 coarse sweep");
    endtask

    task automatic t_home_group();
        logic [63:0] m;
        issue(2'd1, 6'd9);
        issue(2'd1, 6'd12);
        expect_entry(1'b1, 1'b1, 8'h02, "R4 same group");
        m = '0;
        for (int n = 8; n < 16; n++) if (n != int'(HOME)) m[n] = 1'b1;
        issue(2'd3, 6'd0);
        run_sweep(m, 1'b0, "R9 home skipped");
    endtask

    task automatic t_clear();
        bit quiet = 1'b1;
        issue(2'd1, 6'd30);
        issue(2'd1, 6'd50);
        expect_entry(1'b1, 1'b1, 8'h48, "R4 two groups");
        issue(2'd2, 6'd0);
        expect_entry(1'b0, 1'b0, 8'h00, "R7 clear");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (inv_valid || inv_done) quiet = 1'b0;
        end
        check(quiet, "R7 no invalidation", 64'(quiet), 64'd1);
    endtask

    task automatic t_empty_inval();
        issue(2'd3, 6'd0);
        run_sweep(64'd0, 1'b0, "R11 empty sweep");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_coarse();
        t_home_group();
        t_clear();
        t_empty_inval();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule